// File: doc/BRIEF.md
# Traffic-Adaptive Engine Enable Controller

This block sets how many of six packet-processing engines are switched on. The engines sit between the receive and transmit stages of a packet pipeline. It counts packet arrivals between two pulses of a sampling tick. At each tick it captures that count together with the fill level of the shared intermediate queue. From the two captured values it moves a three-level load state machine (low, moderate, heavy). The state selects how many engines are enabled.

Load rises only when the arrival count and the queue backlog both pass their paired thresholds. The default thresholds are 250/450 arrivals per window and 500/750 queued entries, for a queue of 1000 entries. From low, the block adds a single engine (moderate) or goes straight to all six (heavy). It falls back by one engine from moderate to low, and by four engines from heavy to moderate.

Packets must not be lost when engines shut down. An engine chosen for shutdown therefore keeps its enable, and a drain request is raised to it. Its enable is removed only after the engine reports that it is idle. While any drain is in progress, the block takes no new decision. The tick source sets the window length; a 0.5 s window corresponds to that many clock cycles.

Top module: `engine_load_governor`

## Requirements
- R1: After reset, `load_state` is 0 (low), `eng_en` is 6'b000001 and `eng_drain` is 0.
- R2: `load_state` encodes low as 0, moderate as 1 and heavy as 2. When no drain is pending, exactly 1, 2 or 6 engines are enabled in those states, and the enabled engines are always the lowest-numbered ones (bit 0 upward).
- R3: From low, the block moves to moderate (enabling engines 0 and 1) when the captured arrival count is strictly above 250 and the captured queue level is strictly above 500. A value equal to a threshold does not qualify.
- R4: From low or moderate, the block moves to heavy (enabling all six engines) when the captured count is strictly above 450 and the captured queue level is strictly above 750. This test takes priority over R3.
- R5: In moderate, a captured count strictly below 250 returns the block to low. In heavy, a captured count strictly below 450 returns it to moderate. A count equal to the threshold leaves the state unchanged.
- R6: When engines are removed, the highest-numbered engines go first. Each removed engine keeps its `eng_en` bit and has its `eng_drain` bit set. The `eng_en` bit clears on the clock edge at which that engine's `eng_idle` bit is seen high.
- R7: While any `eng_drain` bit is set, a sampling tick causes no state change and no change to the enable mask, whatever the arrival count and queue level.
- R8: Arrivals are counted per window. The count restarts at each tick, and it saturates at its maximum value rather than wrapping.
- R9: A decision made from a tick in cycle T appears on `load_state` and `eng_en` from cycle T+2 onward (one capture register and one state register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| arr_stb | input | 1 | One packet arrival in this cycle |
| q_fill | input | QW | Current intermediate queue occupancy |
| sample_tick | input | 1 | One-cycle pulse that ends a sampling window |
| eng_idle | input | NENG | Per engine: drain complete, no work held |
| eng_en | output | NENG | Per engine enable |
| eng_drain | output | NENG | Per engine request to finish work before shutdown |
| load_state | output | 2 | Current load level (0 low, 1 moderate, 2 heavy) |

## Verification
Windows are driven with arrival counts and queue levels that sit exactly on each threshold, just above it, and with only one of the pair qualifying. These windows separate strict from inclusive comparisons and a conjunctive test from a disjunctive one. A window of 600 arrivals, with the counter narrowed to 9 bits, separates saturation from wrap-around, and the empty window that follows shows that the count restarts. Drain stimulus holds the idle flags low, then raises them one engine at a time, with a tick in the middle. This shows that removed engines stay enabled until idle and that decisions are frozen while a drain is pending.

// File: rtl/elg_pkg.sv
package elg_pkg;
  typedef enum logic [1:0] {
    LD_LOW   = 2'd0,
    LD_MOD   = 2'd1,
    LD_HEAVY = 2'd2
  } load_e;
endpackage

// File: rtl/elg_rate_window.sv
// Counts arrivals per window and captures count and queue level at the tick.
module elg_rate_window #(
  parameter int CW = 16,
  parameter int QW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arr_stb,
  input  logic          sample_tick,
  input  logic [QW-1:0] q_fill,
  output logic [CW-1:0] rate_lat,
  output logic [QW-1:0] q_lat,
  output logic          eval
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (sample_tick)
      cnt_nx = {{(CW-1){1'b0}}, arr_stb};
    else if (arr_stb && (cnt_q != CMAX))
      cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rate_lat <= '0;
      q_lat    <= '0;
      eval     <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      eval  <= sample_tick;
      if (sample_tick) begin
        rate_lat <= cnt_q;
        q_lat    <= q_fill;
      end
    end
  end
endmodule

// File: rtl/elg_load_fsm.sv
// Three-level load state machine; emits the next engine target count.
module elg_load_fsm
  import elg_pkg::*;
#(
  parameter int NENG    = 6,
  parameter int CW      = 16,
  parameter int QW      = 10,
  parameter int RATE_LO = 250,
  parameter int RATE_HI = 450,
  parameter int Q_LO    = 500,
  parameter int Q_HI    = 750,
  parameter int TW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval,
  input  logic          busy,
  input  logic [CW-1:0] rate,
  input  logic [QW-1:0] qv,
  output load_e         state,
  output logic [TW-1:0] tgt_nx
);
  localparam logic [CW-1:0] R_LO = CW'(RATE_LO);
  localparam logic [CW-1:0] R_HI = CW'(RATE_HI);
  localparam logic [QW-1:0] L_LO = QW'(Q_LO);
  localparam logic [QW-1:0] L_HI = QW'(Q_HI);

  load_e st_nx;
  logic  go_heavy, go_mod;

  assign go_heavy = (rate > R_HI) && (qv > L_HI);
  assign go_mod   = (rate > R_LO) && (qv > L_LO);

  always_comb begin
    st_nx = state;
    if (eval && !busy) begin
      unique case (state)
        LD_LOW: begin
          if (go_heavy)    st_nx = LD_HEAVY;
          else if (go_mod) st_nx = LD_MOD;
        end
        LD_MOD: begin
          if (go_heavy)          st_nx = LD_HEAVY;
          else if (rate < R_LO)  st_nx = LD_LOW;
        end
        LD_HEAVY: begin
          if (rate < R_HI)       st_nx = LD_MOD;
        end
        default: st_nx = LD_LOW;
      endcase
    end
  end

  always_comb begin
    unique case (st_nx)
      LD_MOD:   tgt_nx = TW'(2);
      LD_HEAVY: tgt_nx = TW'(NENG);
      default:  tgt_nx = TW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LD_LOW;
    else        state <= st_nx;
  end
endmodule

// File: rtl/elg_engine_mask.sv
// Per-engine enable with drain-before-off.
module elg_engine_mask #(
  parameter int NENG = 6,
  parameter int TW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   tgt_nx,
  input  logic [NENG-1:0] eng_idle,
  output logic [NENG-1:0] eng_en,
  output logic [NENG-1:0] eng_drain
);
  logic [TW-1:0] tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= TW'(1);
    else        tgt_q <= tgt_nx;
  end

  for (genvar i = 0; i < NENG; i++) begin : g_eng
    logic keep_nx, keep_q, en_nx;
    assign keep_nx = TW'(i) < tgt_nx;
    assign keep_q  = TW'(i) < tgt_q;
    assign en_nx   = keep_nx | (eng_en[i] & ~eng_idle[i]);
    assign eng_drain[i] = eng_en[i] & ~keep_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eng_en[i] <= (i == 0);
      else        eng_en[i] <= en_nx;
    end
  end
endmodule

// File: rtl/engine_load_governor.sv
module engine_load_governor
  import elg_pkg::*;
#(
  parameter int NENG    = 6,
  parameter int QCAP    = 1000,
  parameter int CW      = 16,
  parameter int RATE_LO = 250,
  parameter int RATE_HI = 450,
  parameter int QW      = $clog2(QCAP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arr_stb,
  input  logic [QW-1:0]   q_fill,
  input  logic            sample_tick,
  input  logic [NENG-1:0] eng_idle,
  output logic [NENG-1:0] eng_en,
  output logic [NENG-1:0] eng_drain,
  output logic [1:0]      load_state
);
  localparam int Q_LO = QCAP / 2;
  localparam int Q_HI = (3 * QCAP) / 4;
  localparam int TW   = $clog2(NENG + 1);

  logic [1:0]    rst_sync;
  logic          srst_n;
  logic [CW-1:0] rate_lat;
  logic [QW-1:0] q_lat;
  logic          eval;
  load_e         state;
  logic [TW-1:0] tgt_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  elg_rate_window #(.CW(CW), .QW(QW)) u_win (
    .clk(clk), .rst_n(srst_n), .arr_stb(arr_stb), .sample_tick(sample_tick),
    .q_fill(q_fill), .rate_lat(rate_lat), .q_lat(q_lat), .eval(eval)
  );

  elg_load_fsm #(
    .NENG(NENG), .CW(CW), .QW(QW), .RATE_LO(RATE_LO), .RATE_HI(RATE_HI),
    .Q_LO(Q_LO), .Q_HI(Q_HI), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(srst_n), .eval(eval), .busy(|eng_drain),
    .rate(rate_lat), .qv(q_lat), .state(state), .tgt_nx(tgt_nx)
  );

  elg_engine_mask #(.NENG(NENG), .TW(TW)) u_mask (
    .clk(clk), .rst_n(srst_n), .tgt_nx(tgt_nx), .eng_idle(eng_idle),
    .eng_en(eng_en), .eng_drain(eng_drain)
  );

  assign load_state = state;
endmodule

// File: rtl/elg_checker.sv
module elg_checker #(
  parameter int NENG = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sample_tick,
  input logic [NENG-1:0] eng_idle,
  input logic [NENG-1:0] eng_en,
  input logic [NENG-1:0] eng_drain,
  input logic [1:0]      load_state
);
  function automatic int want_cnt(input logic [1:0] s);
    case (s)
      2'd1:    return 2;
      2'd2:    return NENG;
      default: return 1;
    endcase
  endfunction

  // R2
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_state != 2'd3);

  // R2
  low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng_en & (eng_en + 1'b1)) == '0) && eng_en[0]);

  // R2
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_drain == '0) |-> ($countones(eng_en) == want_cnt(load_state)));

  // R6
  off_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(eng_en) & ~eng_en) & ~$past(eng_idle)) == '0));

  // R6
  drain_is_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_drain & ~eng_en) == '0);

  // R9
  change_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(load_state) |-> $past(sample_tick, 2));

  // R7
  frozen_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_drain != '0) |=> $stable(load_state));
endmodule

bind engine_load_governor elg_checker #(.NENG(NENG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .eng_idle(eng_idle),
  .eng_en(eng_en), .eng_drain(eng_drain), .load_state(load_state)
);

// File: tb/sim_engine_load_governor.sv
module sim_engine_load_governor;
  localparam int PERIOD = 10;
  localparam int NENG   = 6;
  localparam int QW     = 10;
  localparam int CW     = 9;

  typedef struct {
    logic [1:0]      st;
    logic [NENG-1:0] en;
    logic [NENG-1:0] dr;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arr_stb = 1'b0;
  logic [QW-1:0] q_fill = '0;
  logic sample_tick = 1'b0;
  logic [NENG-1:0] eng_idle = '0;
  logic [NENG-1:0] eng_en, eng_drain;
  logic [1:0] load_state;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  exp_t sb[$];
  event chk_ev;

  always #(PERIOD/2) clk = ~clk;

  engine_load_governor #(.NENG(NENG), .QCAP(1000), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .arr_stb(arr_stb), .q_fill(q_fill),
    .sample_tick(sample_tick), .eng_idle(eng_idle), .eng_en(eng_en),
    .eng_drain(eng_drain), .load_state(load_state)
  );

  // monitor: pop expected item and compare with design outputs
  always @(chk_ev) begin
    exp_t e;
    while (sb.size() > 0) begin
      e = sb.pop_front();
      n_cmp++;
      if (load_state !== e.st || eng_en !== e.en || eng_drain !== e.dr) begin
        n_bad++;
        $display("FAIL %s: got st=%0d en=%b dr=%b expected st=%0d en=%b dr=%b",
                 e.tag, load_state, eng_en, eng_drain, e.st, e.en, e.dr);
      end
    end
  end

  function automatic logic [NENG-1:0] low_bits(input int n);
    logic [NENG-1:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic expect_now(input logic [1:0] st, input logic [NENG-1:0] en,
                            input logic [NENG-1:0] dr, input string tag);
    exp_t e;
    e.st = st; e.en = en; e.dr = dr; e.tag = tag;
    sb.push_back(e);
    ->chk_ev;
    #1;
  endtask

  // one sampling window: n arrivals, queue level q, tick, then wait to T+2
  task automatic window(input int n, input int q);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) arr_stb = 1'b1;
    end
    @(negedge clk) begin arr_stb = 1'b0; q_fill = QW'(q); sample_tick = 1'b1; end
    @(negedge clk) sample_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now(2'd0, 6'b000001, 6'b0, "R1 reset state");

    window(260, 400);
    expect_now(2'd0, low_bits(1), 6'b0, "R3 queue not above 500 stays low");
    window(250, 600);
    expect_now(2'd0, low_bits(1), 6'b0, "R3 rate equal 250 stays low");
    window(260, 501);
    expect_now(2'd1, low_bits(2), 6'b0, "R3 R9 low to moderate");
    window(300, 800);
    expect_now(2'd1, low_bits(2), 6'b0, "R4 rate not above 450 stays moderate");
    window(460, 750);
    expect_now(2'd1, low_bits(2), 6'b0, "R4 queue equal 750 stays moderate");
    window(460, 751);
    expect_now(2'd2, low_bits(6), 6'b0, "R4 moderate to heavy");
    window(450, 0);
    expect_now(2'd2, low_bits(6), 6'b0, "R5 rate equal 450 stays heavy");
    window(100, 0);
    expect_now(2'd1, low_bits(6), 6'b111100, "R5 R6 heavy to moderate drains four");

    @(negedge clk) eng_idle = 6'b100000;
    @(negedge clk);
    expect_now(2'd1, low_bits(5), 6'b011100, "R6 engine 5 off after idle");
    eng_idle = 6'b0;
    window(0, 0);
    expect_now(2'd1, low_bits(5), 6'b011100, "R7 tick ignored while draining");
    @(negedge clk) eng_idle = 6'b111111;
    @(negedge clk);
    expect_now(2'd1, low_bits(2), 6'b0, "R6 drain complete");
    eng_idle = 6'b0;

    window(249, 0);
    expect_now(2'd0, low_bits(2), 6'b000010, "R5 R6 moderate to low drains engine 1");
    @(negedge clk) eng_idle = 6'b000010;
    @(negedge clk);
    expect_now(2'd0, low_bits(1), 6'b0, "R6 engine 1 off");
    eng_idle = 6'b0;

    window(600, 900);
    expect_now(2'd2, low_bits(6), 6'b0, "R8 R4 saturated count goes heavy from low");
    window(0, 900);
    expect_now(2'd1, low_bits(6), 6'b111100, "R8 count restarts at tick");
    @(negedge clk) eng_idle = 6'b111111;
    @(negedge clk);
    expect_now(2'd1, low_bits(2), 6'b0, "R2 two engines in moderate");
    eng_idle = 6'b0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected end");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule